// File: doc/BRIEF.md
# Playback Byte Counter with Terminal-Count Interrupt

This block sits beside a DMA-fed audio playback path. Software programs a sample count as two byte-wide halves, a format byte and a few control bits. The block turns the sample count into a byte count, using the sample width and the channel count. While playback is enabled and the configuration is legal, it requests DMA. It counts each byte the DMA controller moves. When the programmed number of bytes has gone by, it raises an interrupt.

Bytes are counted only while interrupts are enabled. The interrupt stays asserted until software clears it. An illegal format or sample-rate selection withholds the DMA request. A zero terminal count with interrupts enabled does the same, so a transfer can never run past a count it cannot reach.

Top module: `pb_xfer_irq`

## Requirements
- R1: After reset, `dma_req`, `pi_set` and `irq` are all 0.
- R2: `dma_req` is registered. One cycle after `play_en`=1 is sampled with a legal configuration and no stall, it is 1. One cycle after `play_en`=0 is sampled, it is 0.
- R3: A format byte with bit 0 = 0 and rate index bits 3:1 equal to 4 or 5 is an illegal rate. While it is applied, `dma_req` is held at 0. With bit 0 = 1, every index is legal.
- R4: The format code is taken from bits 6:5 of the format byte, zero-extended, when `ext_mode`=0. When `ext_mode`=1 it is taken from bits 7:5. Codes 4, 5 and 7 are illegal and hold `dma_req` at 0. With `ext_mode`=0, bit 7 has no effect.
- R5: The terminal byte count is {`base_hi`,`base_lo`} shifted left. The shift equals the stereo bit (bit 4) for codes 0, 1 and 3. It equals the stereo bit plus 1 for codes 2 and 6.
- R6: A byte counts only on a cycle where `xfer_stb`=1, `irq_en`=1 and `dma_req`=1. Strobes taken while `irq_en`=0 leave the count unchanged.
- R7: The counted byte that reaches the terminal count causes, one cycle later, a one-cycle `pi_set` pulse and `irq`=1. The count then restarts from zero.
- R8: `irq` stays at 1 until a cycle with `irq_clr`=1 clears it. A terminal hit in the same cycle as `irq_clr` wins, and `irq` stays 1.
- R9: A rising edge of `play_en` restarts the count at zero.
- R10: With `irq_en`=1 and a terminal count of zero, `dma_req` is held at 0 and no interrupt is raised.
- R11: Strobes arriving while `dma_req`=0 are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_hi | input | HALF_W | Upper half of the sample count |
| base_lo | input | HALF_W | Lower half of the sample count |
| fmt_cfg | input | 8 | Format byte: code, stereo, rate index, crystal |
| ext_mode | input | 1 | Selects the 3-bit format code |
| play_en | input | 1 | Playback enable |
| irq_en | input | 1 | Interrupt and counting enable |
| xfer_stb | input | 1 | One DMA byte moved this cycle |
| irq_clr | input | 1 | Clear the interrupt line |
| dma_req | output | 1 | DMA request |
| pi_set | output | 1 | One-cycle playback-interrupt set pulse |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default 8-bit halves, so the count register is 18 bits wide. Small sample counts of 0 to 3 are programmed, which keeps every terminal value within a few strobes. These small counts reach the zero-count stall, mono and stereo shifts of 0, 1 and 2, a restart partway through a count, and a terminal hit that lands on the same cycle as a clear. A behavioural model is compared with the outputs on every cycle, while directed checks cover the legal and illegal format and rate codes in both code widths.

// File: rtl/pb_xfer_pkg.sv
package pb_xfer_pkg;
  localparam int MAX_SHIFT = 2;

  typedef enum logic [2:0] {
    FMT_U8    = 3'd0,
    FMT_ULAW  = 3'd1,
    FMT_S16LE = 3'd2,
    FMT_ALAW  = 3'd3,
    FMT_RSV4  = 3'd4,
    FMT_ADPCM = 3'd5,
    FMT_S16BE = 3'd6,
    FMT_RSV7  = 3'd7
  } pb_fmt_e;

  // bytes per sample as a power of two
  function automatic logic [1:0] byte_shift(pb_fmt_e f, logic stereo);
    logic [1:0] s;
    case (f)
      FMT_S16LE, FMT_S16BE: s = 2'd1 + {1'b0, stereo};
      default:              s = {1'b0, stereo};
    endcase
    return s;
  endfunction

  function automatic logic fmt_legal(pb_fmt_e f);
    return !(f == FMT_RSV4 || f == FMT_ADPCM || f == FMT_RSV7);
  endfunction
endpackage

// File: rtl/pb_fmt_decode.sv
module pb_fmt_decode
  import pb_xfer_pkg::*;
(
  input  logic [7:0] fmt_cfg,
  input  logic       ext_mode,
  output logic       cfg_ok,
  output logic [1:0] shift
);
  pb_fmt_e    code;
  logic [2:0] rate_idx;
  logic       rate_bad;

  always_comb begin
    code     = ext_mode ? pb_fmt_e'(fmt_cfg[7:5]) : pb_fmt_e'({1'b0, fmt_cfg[6:5]});
    rate_idx = fmt_cfg[3:1];
    rate_bad = !fmt_cfg[0] && (rate_idx == 3'd4 || rate_idx == 3'd5);
    cfg_ok   = fmt_legal(code) && !rate_bad;
    shift    = byte_shift(code, fmt_cfg[4]);
  end
endmodule

// File: rtl/pb_byte_counter.sv
module pb_byte_counter #(
  parameter int TERM_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  input  logic [TERM_W-1:0] term,
  output logic              hit
);
  logic [TERM_W-1:0] cnt_q;
  logic [TERM_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + TERM_W'(1);
  assign hit     = step && !restart && (cnt_nxt == term);

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt_q <= '0;
    else if (step)
      cnt_q <= hit ? '0 : cnt_nxt;
  end
endmodule

// File: rtl/pb_xfer_irq.sv
module pb_xfer_irq
  import pb_xfer_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] base_hi,
  input  logic [HALF_W-1:0] base_lo,
  input  logic [7:0]        fmt_cfg,
  input  logic              ext_mode,
  input  logic              play_en,
  input  logic              irq_en,
  input  logic              xfer_stb,
  input  logic              irq_clr,
  output logic              dma_req,
  output logic              pi_set,
  output logic              irq
);
  localparam int CNT_W  = 2 * HALF_W;
  localparam int TERM_W = CNT_W + MAX_SHIFT;

  logic              cfg_ok;
  logic [1:0]        shift;
  logic [TERM_W-1:0] term;
  logic              stall;
  logic              run_q;
  logic              start;
  logic              step;
  logic              hit;

  pb_fmt_decode u_dec (
    .fmt_cfg (fmt_cfg),
    .ext_mode(ext_mode),
    .cfg_ok  (cfg_ok),
    .shift   (shift)
  );

  assign term  = TERM_W'({base_hi, base_lo}) << shift;
  assign stall = irq_en && (term == '0);
  assign start = play_en && !run_q;
  assign step  = xfer_stb && irq_en && dma_req;

  pb_byte_counter #(.TERM_W(TERM_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .restart(start),
    .step   (step),
    .term   (term),
    .hit    (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      dma_req <= 1'b0;
      pi_set  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      run_q   <= play_en;
      dma_req <= play_en && cfg_ok && !stall;
      pi_set  <= hit;
      if (hit)
        irq <= 1'b1;
      else if (irq_clr)
        irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pb_xfer_irq_chk.sv
module pb_xfer_irq_chk (
  input logic clk,
  input logic rst,
  input logic play_en,
  input logic irq_en,
  input logic xfer_stb,
  input logic irq_clr,
  input logic cfg_ok,
  input logic dma_req,
  input logic pi_set,
  input logic irq
);
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(play_en)); // R2
  AST_BAD_CFG_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> !dma_req); // R3
  AST_PI_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    pi_set |-> $past(xfer_stb && irq_en && dma_req)); // R6
  AST_PI_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    pi_set |-> irq); // R7
  AST_IRQ_ROSE_FROM_PI: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> pi_set); // R7
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_clr |=> irq); // R8
endmodule

bind pb_xfer_irq pb_xfer_irq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .play_en (play_en),
  .irq_en  (irq_en),
  .xfer_stb(xfer_stb),
  .irq_clr (irq_clr),
  .cfg_ok  (cfg_ok),
  .dma_req (dma_req),
  .pi_set  (pi_set),
  .irq     (irq)
);

// File: tb/pb_xfer_irq_tb.sv
module pb_xfer_irq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] base_hi = 8'd0, base_lo = 8'd0, fmt_cfg = 8'h01;
  logic       ext_mode = 1'b0, play_en = 1'b0, irq_en = 1'b0;
  logic       xfer_stb = 1'b0, irq_clr = 1'b0;
  logic       dma_req, pi_set, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pb_xfer_irq u_dut (
    .clk(clk), .rst(rst), .base_hi(base_hi), .base_lo(base_lo),
    .fmt_cfg(fmt_cfg), .ext_mode(ext_mode), .play_en(play_en),
    .irq_en(irq_en), .xfer_stb(xfer_stb), .irq_clr(irq_clr),
    .dma_req(dma_req), .pi_set(pi_set), .irq(irq)
  );

  // behavioural reference
  int m_cnt = 0;
  bit m_req = 0, m_pi = 0, m_irq = 0, m_prev = 0;

  function automatic int code_of(logic [7:0] f, logic ext);
    return ext ? int'(f[7:5]) : int'(f[6:5]);
  endfunction

  function automatic bit legal(logic [7:0] f, logic ext);
    int c = code_of(f, ext);
    int idx = int'(f[3:1]);
    if (c == 4 || c == 5 || c == 7) return 0;
    if (f[0] == 1'b0 && (idx == 4 || idx == 5)) return 0;
    return 1;
  endfunction

  function automatic int term_of(logic [7:0] f, logic ext, logic [7:0] hi, logic [7:0] lo);
    int c = code_of(f, ext);
    int sh = (c == 2 || c == 6) ? 1 + int'(f[4]) : int'(f[4]);
    return (int'(hi) * 256 + int'(lo)) * (1 << sh);
  endfunction

  always @(posedge clk) begin
    int t;
    t = term_of(fmt_cfg, ext_mode, base_hi, base_lo);
    if (rst) begin
      m_cnt = 0; m_req = 0; m_pi = 0; m_irq = 0; m_prev = 0;
    end else begin
      m_pi = 0;
      if (play_en && !m_prev) m_cnt = 0;
      else if (xfer_stb && irq_en && m_req) begin
        if (m_cnt + 1 == t) begin m_cnt = 0; m_pi = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (m_pi) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      m_req  = play_en && legal(fmt_cfg, ext_mode) && !(irq_en && t == 0);
      m_prev = play_en;
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) begin
      checks++;
      if (dma_req !== m_req) begin errors++; $display("FAIL R2 model dma_req act=%0b exp=%0b @%0t", dma_req, m_req, $time); end
      checks++;
      if (pi_set !== m_pi) begin errors++; $display("FAIL R7 model pi_set act=%0b exp=%0b @%0t", pi_set, m_pi, $time); end
      checks++;
      if (irq !== m_irq) begin errors++; $display("FAIL R8 model irq act=%0b exp=%0b @%0t", irq, m_irq, $time); end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b @%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) xfer_stb = 1'b1;
      @(negedge clk) xfer_stb = 1'b0;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk("R1 dma_req", dma_req, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 pi_set", pi_set, 1'b0);
    @(negedge clk) rst = 1'b0;

    // mono u8, 3 samples -> 3 bytes
    base_lo = 8'd3; fmt_cfg = 8'h01; irq_en = 1'b1;
    @(negedge clk) play_en = 1'b1;
    cyc(1);
    chk("R2 req up", dma_req, 1'b1);
    strobe(2);
    chk("R5 mono no irq at 2", irq, 1'b0);
    strobe(1);
    chk("R7 irq at 3", irq, 1'b1);
    clear_irq();
    chk("R8 cleared", irq, 1'b0);

    // stereo 16-bit LE, 2 samples -> 8 bytes
    base_lo = 8'd2; fmt_cfg = 8'h51;
    strobe(7);
    chk("R5 stereo16 no irq at 7", irq, 1'b0);
    strobe(1);
    chk("R5 stereo16 irq at 8", irq, 1'b1);
    clear_irq();

    // counting gated by irq_en: 5 strobes ignored
    @(negedge clk) irq_en = 1'b0;
    strobe(5);
    @(negedge clk) irq_en = 1'b1;
    strobe(7);
    chk("R6 disabled strobes not counted", irq, 1'b0);
    strobe(1);
    chk("R6 irq after full count", irq, 1'b1);
    clear_irq();

    // illegal rate
    fmt_cfg = 8'h08; cyc(2);
    chk("R3 bad rate", dma_req, 1'b0);
    fmt_cfg = 8'h09; cyc(2);
    chk("R3 crystal1 idx4 ok", dma_req, 1'b1);

    // format code width
    fmt_cfg = 8'hE1; ext_mode = 1'b1; cyc(2);
    chk("R4 ext code7 rejected", dma_req, 1'b0);
    ext_mode = 1'b0; cyc(2);
    chk("R4 bit7 ignored non-ext", dma_req, 1'b1);
    fmt_cfg = 8'hA1; ext_mode = 1'b1; cyc(2);
    chk("R4 ext code5 rejected", dma_req, 1'b0);
    // code 6 mono: shift 1, 3 samples -> 6 bytes
    fmt_cfg = 8'hC1; base_lo = 8'd3;
    @(negedge clk) play_en = 1'b0;
    @(negedge clk) play_en = 1'b1;
    cyc(1);
    strobe(5);
    chk("R5 code6 no irq at 5", irq, 1'b0);
    strobe(1);
    chk("R5 code6 irq at 6", irq, 1'b1);
    clear_irq();
    ext_mode = 1'b0; fmt_cfg = 8'h01;

    // zero terminal stalls
    base_lo = 8'd0; cyc(2);
    chk("R10 zero stall", dma_req, 1'b0);
    strobe(3);
    chk("R10 no irq", irq, 1'b0);
    @(negedge clk) irq_en = 1'b0;
    cyc(1);
    chk("R10 no stall without irq_en", dma_req, 1'b1);
    @(negedge clk) irq_en = 1'b1; base_lo = 8'd3;
    cyc(1);

    // restart on play_en rise
    @(negedge clk) play_en = 1'b0;
    @(negedge clk) play_en = 1'b1;
    cyc(1);
    strobe(2);
    @(negedge clk) play_en = 1'b0;
    @(negedge clk) play_en = 1'b1;
    cyc(1);
    strobe(2);
    chk("R9 restarted count", irq, 1'b0);
    strobe(1);
    chk("R9 irq after restart", irq, 1'b1);
    clear_irq();

    // strobes while request low are ignored
    strobe(1);
    fmt_cfg = 8'hA1; ext_mode = 1'b1; cyc(2);
    chk("R11 req low", dma_req, 1'b0);
    strobe(5);
    fmt_cfg = 8'h01; ext_mode = 1'b0; cyc(2);
    strobe(1);
    chk("R11 ignored strobes", irq, 1'b0);
    // final byte with simultaneous clear: set wins
    @(negedge clk) begin xfer_stb = 1'b1; irq_clr = 1'b1; end
    @(negedge clk) begin xfer_stb = 1'b0; irq_clr = 1'b0; end
    chk("R8 set beats clear", irq, 1'b1);

    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule